// File: doc/BRIEF.md
# Micro-Address Sequencer with Return Stack

This block keeps the current address into a microcode store of 4608 words and updates it once per clock from a 3-bit command and a 13-bit target. Each cycle the controller can hold the address, step it by one, jump to the target, enter a new routine at the target, call a micro-subroutine, or return from one. A three-entry hardware stack stores return addresses, so subroutines can nest up to three deep.

The registered address is also split into the three select fields that the ROM decode logic needs: a group of eight rows, a row inside that group, and a column inside a 16-wide column set. Only 36 row groups are populated, so the block flags any address whose group field lies above that range. Two sticky flags report stack misuse: a call with the stack already full, and a return with the stack empty. The ROM array and the logic that produces instruction entry points are outside this block.

Top module: `uaddr_sequencer`

## Requirements
- R1: While `rst` is high on a clock edge, the address is cleared to 0, the return stack is emptied and both sticky flags are cleared.
- R2: Opcode 0 (hold), and the unused codes 6 and 7, leave the address and the return stack unchanged.
- R3: Opcode 2 (step) sets the address to the current address plus one, modulo 8192, so 8191 steps to 0.
- R4: Opcode 3 (jump) sets the address to `target` and leaves the return stack unchanged.
- R5: Opcode 1 (entry) sets the address to `target` and empties the return stack, so a following return finds no saved address.
- R6: Opcode 4 (call), with fewer than three saved addresses, pushes the current address plus one (modulo 8192) and sets the address to `target`.
- R7: Opcode 5 (return), with at least one saved address, sets the address to the most recently pushed address and removes it, in last-in first-out order over three nesting levels.
- R8: A call with three saved addresses leaves the address and the stack unchanged and sets `stk_ovf`, which stays high until reset.
- R9: A return with an empty stack leaves the address unchanged and sets `stk_unf`, which stays high until reset.
- R10: `grp_sel` equals address bits [12:7], `row_sel` equals bits [6:4] and `col_sel` equals bits [3:0].
- R11: `addr_oor` is high exactly when the group field is 36 or more, that is, when the address is 4608 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Command: 0 hold, 1 entry, 2 step, 3 jump, 4 call, 5 return, 6-7 hold |
| target | input | 13 | Address used by entry, jump and call |
| addr | output | 13 | Current micro-address (registered) |
| grp_sel | output | 6 | Row-group select, address bits [12:7] |
| row_sel | output | 3 | Row-in-group select, address bits [6:4] |
| col_sel | output | 4 | Column select, address bits [3:0] |
| addr_oor | output | 1 | Address lies beyond the populated row groups |
| stk_ovf | output | 1 | Sticky: a call arrived with the stack full |
| stk_unf | output | 1 | Sticky: a return arrived with the stack empty |

## Verification
The assertions assume that `op` and `target` are known and stable across each rising edge once reset is released, and that the unused codes behave like hold; they do not model stack depth, so call and return ordering is left to the bench. The bench drives every command half a period before the edge it takes effect on and returns `op` to hold right after, so each command acts for exactly one cycle. Nesting past three levels and returning on an empty stack are provoked on purpose, and reset is reapplied before each scenario that needs the sticky flags clear.

// File: rtl/uaddr_pkg.sv
package uaddr_pkg;

  typedef enum logic [2:0] {
    UOP_HOLD  = 3'd0,
    UOP_ENTRY = 3'd1,
    UOP_STEP  = 3'd2,
    UOP_JUMP  = 3'd3,
    UOP_CALL  = 3'd4,
    UOP_RET   = 3'd5
  } uop_e;

  localparam int UOP_W = 3;

endpackage

// File: rtl/uaddr_ret_stack.sv
// Register-based LIFO for return addresses. Slots carry no reset; only the
// occupancy count is cleared, which is all that defines the stack contents.
module uaddr_ret_stack #(
  parameter int W     = 13,
  parameter int DEPTH = 3,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic         flush,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top_data,
  output logic         full,
  output logic         empty
);

  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     slot [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (push && cnt == CNT_W'(i)) begin
          slot[i] <= push_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt <= '0;
    end else if (push) begin
      cnt <= cnt + CNT_W'(1);
    end else if (pop) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_comb begin
    top_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt == CNT_W'(i + 1)) begin
        top_data = slot[i];
      end
    end
  end

  assign full  = (cnt == CNT_W'(DEPTH));
  assign empty = (cnt == '0);

endmodule

// File: rtl/uaddr_next_sel.sv
// Decodes the command into the next address and the stack controls.
module uaddr_next_sel
  import uaddr_pkg::*;
#(
  parameter int W = 13
) (
  input  logic [UOP_W-1:0] op,
  input  logic [W-1:0]     cur,
  input  logic [W-1:0]     target,
  input  logic [W-1:0]     stk_top,
  input  logic             stk_full,
  input  logic             stk_empty,
  output logic [W-1:0]     nxt,
  output logic [W-1:0]     ret_addr,
  output logic             push,
  output logic             pop,
  output logic             flush,
  output logic             ovf_set,
  output logic             unf_set
);

  assign ret_addr = cur + W'(1);

  always_comb begin
    nxt     = cur;
    push    = 1'b0;
    pop     = 1'b0;
    flush   = 1'b0;
    ovf_set = 1'b0;
    unf_set = 1'b0;
    case (uop_e'(op))
      UOP_ENTRY: begin
        nxt   = target;
        flush = 1'b1;
      end
      UOP_STEP: nxt = ret_addr;
      UOP_JUMP: nxt = target;
      UOP_CALL: begin
        if (stk_full) begin
          ovf_set = 1'b1;
        end else begin
          push = 1'b1;
          nxt  = target;
        end
      end
      UOP_RET: begin
        if (stk_empty) begin
          unf_set = 1'b1;
        end else begin
          pop = 1'b1;
          nxt = stk_top;
        end
      end
      default: nxt = cur;
    endcase
  end

endmodule

// File: rtl/uaddr_field_split.sv
// Splits the micro-address into group, row and column selects.
module uaddr_field_split #(
  parameter int W          = 13,
  parameter int ROW_W      = 3,
  parameter int COL_W      = 4,
  parameter int NUM_GROUPS = 36,
  localparam int GRP_W     = W - ROW_W - COL_W
) (
  input  logic [W-1:0]     addr,
  output logic [GRP_W-1:0] grp,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             oor
);

  localparam logic [GRP_W-1:0] GRP_LIMIT = GRP_W'(NUM_GROUPS);

  assign col = addr[COL_W-1:0];
  assign row = addr[COL_W +: ROW_W];
  assign grp = addr[W-1 -: GRP_W];
  assign oor = (grp >= GRP_LIMIT);

endmodule

// File: rtl/uaddr_sequencer.sv
module uaddr_sequencer
  import uaddr_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int ROW_W      = 3,
  parameter int COL_W      = 4,
  parameter int NUM_GROUPS = 36,
  parameter int STK_DEPTH  = 3,
  localparam int GRP_W     = ADDR_W - ROW_W - COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [UOP_W-1:0]  op,
  input  logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] addr,
  output logic [GRP_W-1:0]  grp_sel,
  output logic [ROW_W-1:0]  row_sel,
  output logic [COL_W-1:0]  col_sel,
  output logic              addr_oor,
  output logic              stk_ovf,
  output logic              stk_unf
);

  logic [ADDR_W-1:0] nxt, ret_addr, stk_top;
  logic              push, pop, flush, ovf_set, unf_set;
  logic              stk_full, stk_empty;

  uaddr_next_sel #(.W(ADDR_W)) u_next (
    .op        (op),
    .cur       (addr),
    .target    (target),
    .stk_top   (stk_top),
    .stk_full  (stk_full),
    .stk_empty (stk_empty),
    .nxt       (nxt),
    .ret_addr  (ret_addr),
    .push      (push),
    .pop       (pop),
    .flush     (flush),
    .ovf_set   (ovf_set),
    .unf_set   (unf_set)
  );

  uaddr_ret_stack #(.W(ADDR_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .flush     (flush),
    .push_data (ret_addr),
    .top_data  (stk_top),
    .full      (stk_full),
    .empty     (stk_empty)
  );

  uaddr_field_split #(
    .W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .NUM_GROUPS(NUM_GROUPS)
  ) u_split (
    .addr (addr),
    .grp  (grp_sel),
    .row  (row_sel),
    .col  (col_sel),
    .oor  (addr_oor)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      stk_ovf <= 1'b0;
      stk_unf <= 1'b0;
    end else begin
      addr <= nxt;
      if (ovf_set) stk_ovf <= 1'b1;
      if (unf_set) stk_unf <= 1'b1;
    end
  end

endmodule

// File: rtl/uaddr_sequencer_chk.sv
module uaddr_sequencer_chk
  import uaddr_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int ROW_W      = 3,
  parameter int COL_W      = 4,
  parameter int NUM_GROUPS = 36,
  localparam int GRP_W     = ADDR_W - ROW_W - COL_W
) (
  input logic              clk,
  input logic              rst,
  input logic [UOP_W-1:0]  op,
  input logic [ADDR_W-1:0] target,
  input logic [ADDR_W-1:0] addr,
  input logic [GRP_W-1:0]  grp_sel,
  input logic              addr_oor,
  input logic              stk_ovf,
  input logic              stk_unf
);

  localparam logic [ADDR_W-1:0] FIRST_BAD = ADDR_W'(NUM_GROUPS * (1 << (ROW_W + COL_W)));
  localparam logic [GRP_W-1:0]  GRP_LIM   = GRP_W'(NUM_GROUPS);

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (op == UOP_HOLD) |=> $stable(addr));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (op == UOP_STEP) |=> (addr == ADDR_W'($past(addr) + ADDR_W'(1))));

  assert_jump_R4: assert property (@(posedge clk) disable iff (rst)
    (op == UOP_JUMP) |=> (addr == $past(target)));

  assert_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (op == UOP_ENTRY) |=> (addr == $past(target)));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    stk_ovf |=> stk_ovf);

  assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    stk_unf |=> stk_unf);

  assert_oor_high_R11: assert property (@(posedge clk) disable iff (rst)
    addr_oor |-> (addr >= FIRST_BAD));

  assert_oor_low_R11: assert property (@(posedge clk) disable iff (rst)
    !addr_oor |-> (grp_sel < GRP_LIM));

endmodule

bind uaddr_sequencer uaddr_sequencer_chk #(
  .ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W), .NUM_GROUPS(NUM_GROUPS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op       (op),
  .target   (target),
  .addr     (addr),
  .grp_sel  (grp_sel),
  .addr_oor (addr_oor),
  .stk_ovf  (stk_ovf),
  .stk_unf  (stk_unf)
);

// File: tb/uaddr_sequencer_tb.sv
module uaddr_sequencer_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op  = 3'd0;
  logic [12:0] target = '0;
  logic [12:0] addr;
  logic [5:0]  grp_sel;
  logic [2:0]  row_sel;
  logic [3:0]  col_sel;
  logic        addr_oor, stk_ovf, stk_unf;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uaddr_sequencer u_dut (
    .clk(clk), .rst(rst), .op(op), .target(target),
    .addr(addr), .grp_sel(grp_sel), .row_sel(row_sel), .col_sel(col_sel),
    .addr_oor(addr_oor), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Apply one command for exactly one edge; sample 1 time unit after it.
  task automatic step(input logic [2:0] o, input logic [12:0] t);
    @(negedge clk);
    op = o;
    target = t;
    @(posedge clk);
    #1;
    op = 3'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    op = 3'd0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 addr in reset", 32'(addr), 0);
    check("R1 ovf in reset", 32'(stk_ovf), 0);
    check("R1 unf in reset", 32'(stk_unf), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1 / R9: empty stack right after reset
    do_reset();
    step(3'd5, 13'd0);
    check("R9 ret on empty holds addr", 32'(addr), 0);
    check("R9 unf set", 32'(stk_unf), 1);
    check("R8 ovf still clear", 32'(stk_ovf), 0);

    // R2 / R4 / R3
    do_reset();
    step(3'd3, 13'd100);
    check("R4 jump", 32'(addr), 100);
    step(3'd0, 13'd7);
    check("R2 hold op 0", 32'(addr), 100);
    step(3'd6, 13'd7);
    check("R2 hold op 6", 32'(addr), 100);
    step(3'd7, 13'd7);
    check("R2 hold op 7", 32'(addr), 100);
    step(3'd2, 13'd7);
    check("R3 step", 32'(addr), 101);
    step(3'd3, 13'd8191);
    step(3'd2, 13'd0);
    check("R3 step wraps", 32'(addr), 0);

    // R6 / R7 / R8 / R9: nesting to three, then past it
    step(3'd3, 13'd10);
    step(3'd4, 13'd200);
    check("R6 call 1", 32'(addr), 200);
    step(3'd4, 13'd300);
    check("R6 call 2", 32'(addr), 300);
    step(3'd4, 13'd400);
    check("R6 call 3", 32'(addr), 400);
    check("R8 ovf clear at depth 3", 32'(stk_ovf), 0);
    step(3'd4, 13'd500);
    check("R8 fourth call holds addr", 32'(addr), 400);
    check("R8 ovf set", 32'(stk_ovf), 1);
    step(3'd5, 13'd0);
    check("R7 ret level 3", 32'(addr), 301);
    step(3'd5, 13'd0);
    check("R7 ret level 2", 32'(addr), 201);
    step(3'd5, 13'd0);
    check("R7 ret level 1", 32'(addr), 11);
    check("R9 unf clear before misuse", 32'(stk_unf), 0);
    step(3'd5, 13'd0);
    check("R9 ret on empty holds", 32'(addr), 11);
    check("R9 unf set", 32'(stk_unf), 1);
    step(3'd0, 13'd0);
    check("R8 ovf sticky", 32'(stk_ovf), 1);
    check("R9 unf sticky", 32'(stk_unf), 1);

    // R4: jump inside a subroutine keeps the stack
    do_reset();
    step(3'd3, 13'd20);
    step(3'd4, 13'd50);
    step(3'd3, 13'd60);
    check("R4 jump in sub", 32'(addr), 60);
    step(3'd5, 13'd0);
    check("R4 stack kept across jump", 32'(addr), 21);

    // R6: return address wraps past 8191
    step(3'd3, 13'd8191);
    step(3'd4, 13'd5);
    check("R6 call from top", 32'(addr), 5);
    step(3'd5, 13'd0);
    check("R6 pushed addr wraps", 32'(addr), 0);
    check("R9 no unf on valid ret", 32'(stk_unf), 0);

    // R5: entry empties the stack
    step(3'd3, 13'd21);
    step(3'd4, 13'd70);
    step(3'd1, 13'd80);
    check("R5 entry addr", 32'(addr), 80);
    step(3'd5, 13'd0);
    check("R5 ret after entry holds", 32'(addr), 80);
    check("R5 stack flushed (unf)", 32'(stk_unf), 1);

    // R10 / R11: every address
    for (int a = 0; a < 8192; a++) begin
      step(3'd3, 13'(a));
      check("R10 addr", 32'(addr), 32'(a));
      check("R10 grp_sel", 32'(grp_sel), 32'(a / 128));
      check("R10 row_sel", 32'(row_sel), 32'((a / 16) % 8));
      check("R10 col_sel", 32'(col_sel), 32'(a % 16));
      check("R11 addr_oor", 32'(addr_oor), (a >= 36 * 128) ? 32'd1 : 32'd0);
    end

    summary();
    $finish;
  end

endmodule